// File: doc/BRIEF.md
# Hybrid Flash/SAR Conversion Controller

This block sequences one conversion of a 16-bit hybrid converter. A start pulse sends it through a sample phase, a single flash phase that settles the upper bits from a thermometer vector, and a successive-approximation phase that settles the lower bits one per clock. During the search it drives a trial code onto the switches of a binary-weighted capacitor array and reads back one comparator decision for each bit. When the last bit is known it shows the final code and raises a one-cycle done strobe.

Two options cut the work of a conversion. A precision setting ends the search early: the bits below the requested precision are never tested and read as zero. An optional estimate can seed the search. If the estimate's upper field agrees with the flash result, the estimate's lower bits fill the untested part of each trial code, so the array starts close to the expected value. If the fields disagree, the estimate is dropped and a plain search runs.

Top module: `hsar_ctrl`

## Requirements
- R1: During and after reset, sample_o, done_o, code_o and trial_o are all zero and the block is idle.
- R2: A start_i seen in the idle state makes sample_o high for exactly the next cycle. The flash vector is captured in the cycle after that.
- R3: The upper FLASH_W bits of the result equal the number of ones in therm_i, wherever those ones sit, so a bubbled thermometer vector gives the same field as a clean one.
- R4: The search tests bits SAR_W-1 down to the lowest bit inside the precision, one bit per clock. The trial code is the current code with the tested bit set. The bit is kept when cmp_i is 1 (the input is at or above the trial) and cleared when cmp_i is 0. The upper field does not change during the search.
- R5: With an effective precision of N bits, the lowest TOTAL_W-N bits of code_o are zero. done_o goes high on the (N-FLASH_W+3)th rising edge counted from the edge that samples start_i. That count includes N-FLASH_W search cycles.
- R6: A prec_i value below FLASH_W acts as FLASH_W, so there is no search and only the flash field is returned. A value above TOTAL_W acts as TOTAL_W.
- R7: When seed_en_i is 1 at start and seed_i's upper FLASH_W bits equal the flash result, the bits of the trial code below the tested bit come from seed_i, masked to the precision. Otherwise those bits are zero. A seed that equals the true code gives the same result as an unseeded search.
- R8: done_o is a single-cycle pulse. code_o changes only on the edge that raises done_o and holds its value until the next done.
- R9: A start_i pulse that arrives while a conversion is running, including the done cycle, is ignored. It neither restarts the conversion nor queues a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| start_i | input | 1 | Start-of-conversion pulse |
| prec_i | input | PREC_W (5) | Requested precision in bits, latched at start |
| seed_en_i | input | 1 | Use seed_i as the search estimate, latched at start |
| seed_i | input | TOTAL_W (16) | Estimated result, latched at start |
| therm_i | input | THERM_W (31) | Flash comparator thermometer vector |
| cmp_i | input | 1 | Comparator decision: 1 when the input is at or above the trial code |
| trial_o | output | TOTAL_W (16) | Capacitor switch code under test |
| sample_o | output | 1 | Track/hold control, high while sampling |
| done_o | output | 1 | One-cycle end-of-conversion strobe |
| code_o | output | TOTAL_W (16) | Final conversion result |

## Verification
The bench builds the block with TOTAL_W=8 and FLASH_W=3. This leaves 5 search bits and a 7-wide thermometer vector. At that size every input level from 0 to 255 can be converted at every precision setting from 0 to 9. The sweep therefore covers both clamp regions, the flash-only case and the full-length search, and the bench works out each expected code and done latency by masking and counting. Rotating the thermometer vector for each level places bubbles in every position. Separate runs inject seeds that match, seeds that mismatch and seeds that are disabled, and send start pulses in each busy state.

// File: rtl/hsar_pkg.sv
package hsar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SAMPLE = 3'd1,
        ST_FLASH  = 3'd2,
        ST_SAR    = 3'd3,
        ST_DONE   = 3'd4
    } state_e;

endpackage

// File: rtl/hsar_therm_enc.sv
// Bubble-tolerant thermometer-to-binary conversion: the result is the count of ones.
module hsar_therm_enc #(
    parameter int IN_W  = 31,
    parameter int OUT_W = 5
) (
    input  logic [IN_W-1:0]  therm_i,
    output logic [OUT_W-1:0] level_o
);

    always_comb begin
        level_o = '0;
        for (int i = 0; i < IN_W; i++) begin
            level_o = level_o + OUT_W'(therm_i[i]);
        end
    end

endmodule

// File: rtl/hsar_prec_mask.sv
// Clamps the precision setting and derives the kept-bit mask and the last bit index to test.
module hsar_prec_mask #(
    parameter int TOTAL_W = 16,
    parameter int FLASH_W = 5,
    parameter int PREC_W  = 5,
    parameter int IDX_W   = 4
) (
    input  logic [PREC_W-1:0]  prec_i,
    output logic [TOTAL_W-1:0] keep_o,
    output logic [IDX_W-1:0]   last_idx_o,
    output logic               flash_only_o
);

    int n_eff;

    always_comb begin
        n_eff = int'(prec_i);
        if (n_eff < FLASH_W) n_eff = FLASH_W;
        if (n_eff > TOTAL_W) n_eff = TOTAL_W;
        for (int i = 0; i < TOTAL_W; i++) begin
            keep_o[i] = (i >= (TOTAL_W - n_eff));
        end
        last_idx_o   = IDX_W'(TOTAL_W - n_eff);
        flash_only_o = (n_eff == FLASH_W);
    end

endmodule

// File: rtl/hsar_ctrl.sv
module hsar_ctrl
    import hsar_pkg::*;
#(
    parameter int TOTAL_W = 16,
    parameter int FLASH_W = 5,
    parameter int PREC_W  = $clog2(TOTAL_W + 1),
    parameter int THERM_W = (1 << FLASH_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [PREC_W-1:0]  prec_i,
    input  logic               seed_en_i,
    input  logic [TOTAL_W-1:0] seed_i,
    input  logic [THERM_W-1:0] therm_i,
    input  logic               cmp_i,
    output logic [TOTAL_W-1:0] trial_o,
    output logic               sample_o,
    output logic               done_o,
    output logic [TOTAL_W-1:0] code_o
);

    localparam int SAR_W = TOTAL_W - FLASH_W;
    localparam int IDX_W = $clog2(SAR_W + 1);

    typedef struct packed {
        state_e             state;
        logic [TOTAL_W-1:0] code;
        logic [IDX_W-1:0]   idx;
        logic [PREC_W-1:0]  prec;
        logic               seed_en;
        logic [TOTAL_W-1:0] seed;
        logic [TOTAL_W-1:0] out;
    } regs_t;

    regs_t q, d;

    logic [FLASH_W-1:0] flash_lvl;
    logic [TOTAL_W-1:0] keep;
    logic [IDX_W-1:0]   last_idx;
    logic               flash_only;
    logic [TOTAL_W-1:0] bit_oh;
    logic               seed_hit;
    state_e             st_now;

    hsar_therm_enc #(
        .IN_W  (THERM_W),
        .OUT_W (FLASH_W)
    ) u_therm (
        .therm_i (therm_i),
        .level_o (flash_lvl)
    );

    hsar_prec_mask #(
        .TOTAL_W (TOTAL_W),
        .FLASH_W (FLASH_W),
        .PREC_W  (PREC_W),
        .IDX_W   (IDX_W)
    ) u_mask (
        .prec_i       (q.prec),
        .keep_o       (keep),
        .last_idx_o   (last_idx),
        .flash_only_o (flash_only)
    );

    assign bit_oh   = TOTAL_W'(1) << q.idx;
    assign seed_hit = q.seed_en && (q.seed[TOTAL_W-1:SAR_W] == flash_lvl);
    assign st_now   = q.state;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state   = ST_SAMPLE;
                    d.prec    = prec_i;
                    d.seed_en = seed_en_i;
                    d.seed    = seed_i;
                end
            end
            ST_SAMPLE: begin
                d.state = ST_FLASH;
            end
            ST_FLASH: begin
                d.code                  = '0;
                d.code[TOTAL_W-1:SAR_W] = flash_lvl;
                if (seed_hit) begin
                    d.code[SAR_W-1:0] = q.seed[SAR_W-1:0] & keep[SAR_W-1:0];
                end
                d.idx = IDX_W'(SAR_W - 1);
                if (flash_only) begin
                    d.state = ST_DONE;
                    d.out   = d.code;
                end else begin
                    d.state = ST_SAR;
                end
            end
            ST_SAR: begin
                d.code = cmp_i ? (q.code | bit_oh) : (q.code & ~bit_oh);
                if (q.idx == last_idx) begin
                    d.state = ST_DONE;
                    d.out   = d.code;
                end else begin
                    d.idx = q.idx - IDX_W'(1);
                end
            end
            ST_DONE: begin
                d.state = ST_IDLE;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign trial_o  = (q.state == ST_SAR) ? (q.code | bit_oh) : q.code;
    assign sample_o = (q.state == ST_SAMPLE);
    assign done_o   = (q.state == ST_DONE);
    assign code_o   = q.out;

endmodule

module hsar_ctrl_chk
    import hsar_pkg::*;
#(
    parameter int TOTAL_W = 16,
    parameter int FLASH_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               sample_o,
    input logic               done_o,
    input logic [TOTAL_W-1:0] trial_o,
    input logic [TOTAL_W-1:0] code_o,
    input state_e             st
);

    localparam int SAR_W = TOTAL_W - FLASH_W;

    AST_SAMPLE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start_i) |=> sample_o); // R2

    AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o); // R2

    AST_MSB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SAR && $past(st) == ST_SAR) |-> $stable(trial_o[TOTAL_W-1:SAR_W])); // R4

    AST_DONE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(st) == ST_SAR || $past(st) == ST_FLASH)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(code_o)); // R8

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && start_i) |=> !sample_o); // R9

endmodule

bind hsar_ctrl hsar_ctrl_chk #(
    .TOTAL_W (TOTAL_W),
    .FLASH_W (FLASH_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .sample_o (sample_o),
    .done_o   (done_o),
    .trial_o  (trial_o),
    .code_o   (code_o),
    .st       (st_now)
);

// File: tb/sim_hsar_ctrl.sv
module sim_hsar_ctrl;

    localparam int TW = 8;
    localparam int FW = 3;
    localparam int SW = TW - FW;
    localparam int PW = $clog2(TW + 1);
    localparam int TH = (1 << FW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [PW-1:0] prec = '0;
    logic          seed_en = 1'b0;
    logic [TW-1:0] seed = '0;
    logic [TH-1:0] therm = '0;
    logic          cmp;
    logic [TW-1:0] trial;
    logic          sample;
    logic          done;
    logic [TW-1:0] code;
    logic [TW-1:0] vin = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    // behavioural comparator: input at or above the trial level
    assign cmp = (vin >= trial);

    hsar_ctrl #(
        .TOTAL_W (TW),
        .FLASH_W (FW)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .prec_i    (prec),
        .seed_en_i (seed_en),
        .seed_i    (seed),
        .therm_i   (therm),
        .cmp_i     (cmp),
        .trial_o   (trial),
        .sample_o  (sample),
        .done_o    (done),
        .code_o    (code)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_prec(input int p);
        if (p < FW) return FW;
        if (p > TW) return TW;
        return p;
    endfunction

    function automatic int low_mask(input int p);
        return ((1 << TW) - 1) & ~((1 << (TW - eff_prec(p))) - 1);
    endfunction

    function automatic logic [TH-1:0] rot_therm(input int level, input int r);
        int t;
        int rr;
        t  = (1 << level) - 1;
        rr = r % TH;
        if (rr == 0) return TH'(t);
        return TH'(((t << rr) | (t >> (TH - rr))) & ((1 << TH) - 1));
    endfunction

    // extra: -1 none, -2 start during done cycle, k>0 start driven after edge k
    task automatic run(input int v, input int p, input bit sen, input int sd, input int r,
                       input int extra, output int edges, output int result,
                       output int first_trial);
        vin     = TW'(v);
        therm   = rot_therm(v >> SW, r);
        prec    = PW'(p);
        seed_en = sen;
        seed    = TW'(sd);
        start   = 1'b1;
        edges   = 0;
        first_trial = -1;
        forever begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            start = 1'b0;
            if (edges == 3) first_trial = int'(trial);
            if (extra > 0 && edges == extra) start = 1'b1;
            if (done) begin
                if (extra == -2) start = 1'b1;
                break;
            end
            if (edges > 60) break;
        end
        result = int'(code);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int e;
        int res;
        int ft;
        int expc;
        int ex_ft;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(sample == 1'b0 && done == 1'b0, "R1 reset controls", int'({sample, done}), 0);
        chk(code == '0 && trial == '0, "R1 reset codes", int'(code) + int'(trial), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sample == 1'b0 && done == 1'b0 && code == '0, "R1 idle after reset",
            int'({sample, done}), 0);

        // R2: sample strobe timing
        vin = 8'd77;
        therm = rot_therm(77 >> SW, 0);
        prec = PW'(TW);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(sample == 1'b1, "R2 sample high after start", int'(sample), 1);
        @(negedge clk);
        chk(sample == 1'b0, "R2 sample single cycle", int'(sample), 0);
        repeat (12) @(negedge clk);

        // R3 R4 R5 R6 R8: sweep every level at every precision setting
        for (int p = 0; p <= TW + 1; p++) begin
            for (int v = 0; v < (1 << TW); v++) begin
                run(v, p, 1'b0, 0, v + p, -1, e, res, ft);
                expc = v & low_mask(p);
                if (p < FW || p > TW)
                    chk(res == expc, "R6 clamped precision code", res, expc);
                else if (p == TW)
                    chk(res == expc, "R3 R4 full search code", res, expc);
                else
                    chk(res == expc, "R5 reduced precision code", res, expc);
                chk(e == eff_prec(p) - FW + 3, "R5 done latency", e, eff_prec(p) - FW + 3);
                @(negedge clk);
                chk(done == 1'b0 && int'(code) == expc, "R8 done pulse and hold",
                    int'(code), expc);
            end
        end

        // R7: seed with matching upper field, full precision
        for (int v = 0; v < (1 << TW); v += 7) begin
            run(v, TW, 1'b1, v, 3, -1, e, res, ft);
            ex_ft = (v & ~((1 << SW) - 1)) | (1 << (SW - 1)) | (v & ((1 << (SW - 1)) - 1));
            chk(ft == ex_ft, "R7 seeded first trial", ft, ex_ft);
            chk(res == v, "R7 seeded result", res, v);
            @(negedge clk);
        end
        // R7: seed with matching upper field, reduced precision (6 bits)
        for (int v = 0; v < (1 << TW); v += 11) begin
            run(v, 6, 1'b1, v, 1, -1, e, res, ft);
            ex_ft = (v & ~((1 << SW) - 1)) | (1 << (SW - 1)) | (v & 12);
            chk(ft == ex_ft, "R7 seeded masked trial", ft, ex_ft);
            chk(res == (v & low_mask(6)), "R7 seeded masked result", res, v & low_mask(6));
            @(negedge clk);
        end
        // R7: mismatching upper field or disabled seed falls back to zeros
        for (int v = 0; v < (1 << TW); v += 13) begin
            run(v, TW, 1'b1, v ^ (1 << (TW - 1)), 2, -1, e, res, ft);
            ex_ft = (v & ~((1 << SW) - 1)) | (1 << (SW - 1));
            chk(ft == ex_ft, "R7 mismatch fallback trial", ft, ex_ft);
            chk(res == v, "R7 mismatch fallback result", res, v);
            @(negedge clk);
            run(v, TW, 1'b0, v, 2, -1, e, res, ft);
            chk(ft == ex_ft, "R7 disabled seed trial", ft, ex_ft);
            @(negedge clk);
        end

        // R9: start pulses while busy, in each busy state
        for (int k = 1; k <= 5; k++) begin
            run(150 + k, TW, 1'b0, 0, k, k, e, res, ft);
            chk(res == 150 + k, "R9 busy start result", res, 150 + k);
            chk(e == TW - FW + 3, "R9 busy start latency", e, TW - FW + 3);
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            for (int c = 0; c < 4; c++) begin
                chk(sample == 1'b0 && done == 1'b0, "R9 no restart", int'({sample, done}), 0);
                @(negedge clk);
            end
        end
        run(99, 5, 1'b0, 0, 0, -2, e, res, ft);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 4; c++) begin
            chk(sample == 1'b0, "R9 start in done ignored", int'(sample), 0);
            @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule